// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command interface of a banked NOR flash device. It watches bus write cycles on which address and data arrive on separate strobes. The address is captured when the address-valid strobe rises, and a command is taken when the write-enable strobe rises. The block recognises multi-cycle command sequences and turns them into persistent configuration. That configuration is the initial-access wait count for burst reads, a sticky power-saving flag, and a per-sector lock bitmap. Any command that is not recognised sends the decoder back to read mode.

The lock bitmap is combined with three override pins to give the effective lock vector that the rest of the device uses: a write-protect pin and two programming-voltage level pins. Both unlock cycles are AAh written to 555h and then 55h written to 2AAh, where only address bits 11:0 are compared. The sector index is held in the top address bits. All interface pins are plain control and status levels, and nothing on the block's edge uses a valid/ready handshake.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After an asynchronous active-low reset the wait count reads 7, the power-save flag reads 0 and every sector's raw lock bit is set. With neutral overrides (wp_n_i=1, vpp_low_i=0, vpp_high_i=0) every bit of sector_lock_o is then 1.
- R2: A command is decoded once per rising edge of we_i. Holding we_i high does not repeat it. The address used is the one latched at the last rising edge of adv_i, and later changes on addr_i without an adv_i edge are not used.
- R3: The sequence AAh@555h, 55h@2AAh, C0h@x555h sets the wait count to 4 + addr[13:12].
- R4: wait_cycles_o always lies between 4 and 7.
- R5: The sequence AAh@555h, 55h@2AAh, 70h@555h sets pwr_save_o. Only reset clears it.
- R6: The sequence 60h, 60h, 60h@sector writes one sector's raw lock bit. The first two addresses are ignored. In the third write, addr[20:15] selects the sector, addr[6]=0 locks it and addr[6]=1 unlocks it.
- R7: After the first lock write, every further 60h write updates the sector it addresses. Other data values are ignored and keep the stream open. Only F0h leaves the stream.
- R8: F0h at any address returns the decoder to read mode from any step. A wrong data or address value partway through a sequence also aborts it without changing any setting.
- R9: vpp_low_i=1 forces every bit of sector_lock_o to 1.
- R10: wp_n_i=0 forces the two highest-numbered sectors locked.
- R11: With vpp_low_i=0 and vpp_high_i=1, every sector not forced by R10 reads unlocked. The raw bitmap is kept underneath all overrides and shows through again when they are released.
- R12: Asserting reset partway through a sequence or a lock stream restores the R1 state and read mode at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock on which both strobes are sampled |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| adv_i | input | 1 | Address-valid strobe; addr_i is latched on its rising edge |
| addr_i | input | ADDR_W | Word address bus |
| we_i | input | 1 | Write-enable strobe; data_i is decoded on its rising edge |
| data_i | input | 8 | Command data byte |
| wp_n_i | input | 1 | Write protect, low locks the two top sectors |
| vpp_low_i | input | 1 | Programming voltage at logic-low level; locks all sectors |
| vpp_high_i | input | 1 | Programming voltage at high level; unlocks sectors |
| wait_cycles_o | output | 3 | Initial burst access wait cycles, 4 to 7 |
| pwr_save_o | output | 1 | Power-saving mode enabled |
| sector_lock_o | output | SECTORS | Effective lock bit per sector, 1 = locked |

## Verification
On every cycle the assertions check the override logic (R9, R10, R11), the wait-count range, that the power-save flag stays set, and that no setting changes without a fresh write-strobe edge. Sequence recognition cannot be shown by a property. This covers the meaning of each step, aborts on wrong values, the persistence of the lock stream, and the choice of which latched address a command uses. Only the bench's scenarios can show these, with its reference model comparing all outputs every clock.

// File: rtl/fcsd_pkg.sv
package fcsd_pkg;
  typedef enum logic [2:0] {
    ST_READ  = 3'd0,
    ST_UNL1  = 3'd1,
    ST_UNL2  = 3'd2,
    ST_LKP1  = 3'd3,
    ST_LKP2  = 3'd4,
    ST_LKRUN = 3'd5
  } seq_e;

  localparam logic [7:0]  CMD_KEY_A = 8'hAA;
  localparam logic [7:0]  CMD_KEY_B = 8'h55;
  localparam logic [7:0]  CMD_WAIT  = 8'hC0;
  localparam logic [7:0]  CMD_PSAVE = 8'h70;
  localparam logic [7:0]  CMD_LOCK  = 8'h60;
  localparam logic [7:0]  CMD_ABORT = 8'hF0;
  localparam logic [11:0] ADR_KEY_A = 12'h555;
  localparam logic [11:0] ADR_KEY_B = 12'h2AA;
  localparam logic [2:0]  WAIT_DEF  = 3'd7;
endpackage

// File: rtl/fcsd_rise.sv
module fcsd_rise (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/fcsd_seq.sv
module fcsd_seq
  import fcsd_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int SEC_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_evt_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output logic [2:0]        wait_o,
  output logic              psave_o,
  output logic              lk_evt_o,
  output logic [SEC_W-1:0]  lk_sec_o,
  output logic              lk_set_o
);
  seq_e       st_q;
  logic [2:0] wait_q;
  logic       psave_q;
  logic       at_key_a, at_key_b, in_stream;

  assign at_key_a  = (addr_i[11:0] == ADR_KEY_A);
  assign at_key_b  = (addr_i[11:0] == ADR_KEY_B);
  assign in_stream = (st_q == ST_LKP2) || (st_q == ST_LKRUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_READ;
      wait_q  <= WAIT_DEF;
      psave_q <= 1'b0;
    end else if (wr_evt_i) begin
      if (data_i == CMD_ABORT) begin
        st_q <= ST_READ;
      end else begin
        case (st_q)
          ST_READ: begin
            if (data_i == CMD_KEY_A && at_key_a) st_q <= ST_UNL1;
            else if (data_i == CMD_LOCK)          st_q <= ST_LKP1;
            else                                  st_q <= ST_READ;
          end
          ST_UNL1: st_q <= (data_i == CMD_KEY_B && at_key_b) ? ST_UNL2 : ST_READ;
          ST_UNL2: begin
            st_q <= ST_READ;
            if (data_i == CMD_WAIT && at_key_a)       wait_q  <= {1'b1, addr_i[13:12]};
            else if (data_i == CMD_PSAVE && at_key_a) psave_q <= 1'b1;
          end
          ST_LKP1: st_q <= (data_i == CMD_LOCK) ? ST_LKP2 : ST_READ;
          ST_LKP2: st_q <= (data_i == CMD_LOCK) ? ST_LKRUN : ST_READ;
          ST_LKRUN: st_q <= ST_LKRUN;
          default: st_q <= ST_READ;
        endcase
      end
    end
  end

  assign wait_o   = wait_q;
  assign psave_o  = psave_q;
  assign lk_evt_o = wr_evt_i && in_stream && (data_i == CMD_LOCK);
  assign lk_sec_o = addr_i[ADDR_W-1 -: SEC_W];
  assign lk_set_o = ~addr_i[6];
endmodule

// File: rtl/fcsd_lockmap.sv
module fcsd_lockmap #(
  parameter int SECTORS   = 64,
  parameter int BOOT_SECT = 2,
  parameter int SEC_W     = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               evt_i,
  input  logic [SEC_W-1:0]   sec_i,
  input  logic               set_i,
  input  logic               wp_n_i,
  input  logic               vpp_low_i,
  input  logic               vpp_high_i,
  output logic [SECTORS-1:0] lock_o
);
  logic [SECTORS-1:0] raw_q;

  for (genvar i = 0; i < SECTORS; i++) begin : g_sec
    localparam bit IS_BOOT = (i >= SECTORS - BOOT_SECT);
    logic hit;
    assign hit = evt_i && (sec_i == SEC_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   raw_q[i] <= 1'b1;
      else if (hit) raw_q[i] <= set_i;
    end

    if (IS_BOOT) begin : g_boot
      assign lock_o[i] = vpp_low_i | ~wp_n_i | (~vpp_high_i & raw_q[i]);
    end else begin : g_main
      assign lock_o[i] = vpp_low_i | (~vpp_high_i & raw_q[i]);
    end
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int ADDR_W    = 21,
  parameter int SECTORS   = 64,
  parameter int BOOT_SECT = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               adv_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               we_i,
  input  logic [7:0]         data_i,
  input  logic               wp_n_i,
  input  logic               vpp_low_i,
  input  logic               vpp_high_i,
  output logic [2:0]         wait_cycles_o,
  output logic               pwr_save_o,
  output logic [SECTORS-1:0] sector_lock_o
);
  localparam int SEC_W = $clog2(SECTORS);

  logic              adv_rise, we_rise;
  logic [ADDR_W-1:0] addr_q;
  logic              lk_evt, lk_set;
  logic [SEC_W-1:0]  lk_sec;

  fcsd_rise u_adv_rise (.clk(clk), .rst_n(rst_n), .lvl_i(adv_i), .rise_o(adv_rise));
  fcsd_rise u_we_rise  (.clk(clk), .rst_n(rst_n), .lvl_i(we_i),  .rise_o(we_rise));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        addr_q <= '0;
    else if (adv_rise) addr_q <= addr_i;
  end

  fcsd_seq #(.ADDR_W(ADDR_W), .SEC_W(SEC_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_evt_i(we_rise), .addr_i(addr_q), .data_i(data_i),
    .wait_o(wait_cycles_o), .psave_o(pwr_save_o),
    .lk_evt_o(lk_evt), .lk_sec_o(lk_sec), .lk_set_o(lk_set)
  );

  fcsd_lockmap #(.SECTORS(SECTORS), .BOOT_SECT(BOOT_SECT), .SEC_W(SEC_W)) u_map (
    .clk(clk), .rst_n(rst_n), .evt_i(lk_evt), .sec_i(lk_sec), .set_i(lk_set),
    .wp_n_i(wp_n_i), .vpp_low_i(vpp_low_i), .vpp_high_i(vpp_high_i),
    .lock_o(sector_lock_o)
  );
endmodule

// File: rtl/fcsd_chk.sv
module fcsd_chk #(
  parameter int SECTORS   = 64,
  parameter int BOOT_SECT = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               we_i,
  input logic               wp_n_i,
  input logic               vpp_low_i,
  input logic               vpp_high_i,
  input logic [2:0]         wait_cycles_o,
  input logic               pwr_save_o,
  input logic [SECTORS-1:0] sector_lock_o
);
  a_r4_wait_range: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_cycles_o >= 3'd4));

  a_r5_psave_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_save_o |=> pwr_save_o);

  a_r2_no_edge_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_i && !$past(we_i)) |=> ($stable(wait_cycles_o) && $stable(pwr_save_o)));

  a_r9_vpp_low_all: assert property (@(posedge clk) disable iff (!rst_n)
    vpp_low_i |-> (&sector_lock_o));

  a_r10_wp_boot: assert property (@(posedge clk) disable iff (!rst_n)
    !wp_n_i |-> (&sector_lock_o[SECTORS-1 -: BOOT_SECT]));

  a_r11_vpp_high_free: assert property (@(posedge clk) disable iff (!rst_n)
    (vpp_high_i && !vpp_low_i && wp_n_i) |-> (sector_lock_o == '0));
endmodule

bind flash_cmd_decoder fcsd_chk #(.SECTORS(SECTORS), .BOOT_SECT(BOOT_SECT)) u_chk (
  .clk(clk), .rst_n(rst_n), .we_i(we_i), .wp_n_i(wp_n_i), .vpp_low_i(vpp_low_i),
  .vpp_high_i(vpp_high_i), .wait_cycles_o(wait_cycles_o), .pwr_save_o(pwr_save_o),
  .sector_lock_o(sector_lock_o)
);

// File: tb/flash_cmd_decoder_bench.sv
module flash_cmd_decoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 21;
  localparam int NS = 64;

  logic clk = 1'b0, rst_n = 1'b0, adv = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] data = '0;
  logic wp_n = 1'b1, vlo = 1'b0, vhi = 1'b0;
  logic [2:0] wait_o;
  logic ps_o;
  logic [NS-1:0] lock_o;

  int errors = 0, checks = 0;
  int wait_m = 7;
  bit ps_m = 0;
  bit [NS-1:0] raw_m = '1;
  int phase_m = 0;
  logic [AW-1:0] alat_m = '0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_decoder u_flash_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .adv_i(adv), .addr_i(addr), .we_i(we), .data_i(data),
    .wp_n_i(wp_n), .vpp_low_i(vlo), .vpp_high_i(vhi),
    .wait_cycles_o(wait_o), .pwr_save_o(ps_o), .sector_lock_o(lock_o)
  );

  task automatic check(input string tag, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic bit [NS-1:0] eff_lock();
    bit [NS-1:0] r;
    for (int i = 0; i < NS; i++) begin
      if (vlo) r[i] = 1'b1;
      else if (!wp_n && i >= NS-2) r[i] = 1'b1;
      else if (vhi) r[i] = 1'b0;
      else r[i] = raw_m[i];
    end
    return r;
  endfunction

  task automatic model_reset();
    wait_m = 7; ps_m = 0; raw_m = '1; phase_m = 0; alat_m = '0;
  endtask

  // behavioural model of one accepted write, phases: 0 read,1,2 unlock,4,5 lock prefix,6 stream
  task automatic model_write(input logic [7:0] d);
    logic [AW-1:0] a = alat_m;
    if (d == 8'hF0) begin phase_m = 0; return; end
    case (phase_m)
      0: phase_m = (d == 8'hAA && a[11:0] == 12'h555) ? 1 : (d == 8'h60) ? 4 : 0;
      1: phase_m = (d == 8'h55 && a[11:0] == 12'h2AA) ? 2 : 0;
      2: begin
        if (d == 8'hC0 && a[11:0] == 12'h555) wait_m = 4 + int'(a[13:12]);
        else if (d == 8'h70 && a[11:0] == 12'h555) ps_m = 1;
        phase_m = 0;
      end
      4: phase_m = (d == 8'h60) ? 5 : 0;
      default: begin
        if (d == 8'h60) begin raw_m[a[20:15]] = !a[6]; phase_m = 6; end
        else if (phase_m == 5) phase_m = 0;
      end
    endcase
  endtask

  // per-cycle comparison, away from the active edge
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (!done) begin
      check("R3/R4 wait_cycles_o", wait_o, wait_m);
      check("R5 pwr_save_o", ps_o, ps_m);
      check("R6/R7 sector_lock_o", lock_o, eff_lock());
    end
  end

  task automatic bus_write(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; adv = 1'b1; alat_m = a;
    @(negedge clk); adv = 1'b0; data = d; we = 1'b1; model_write(d);
    @(negedge clk); we = 1'b0;
  endtask

  task automatic data_only(input logic [7:0] d, input int hold);
    @(negedge clk); data = d; we = 1'b1; model_write(d);
    repeat (hold) @(negedge clk);
    we = 1'b0;
  endtask

  task automatic unlock2();
    bus_write(21'h000555, 8'hAA);
    bus_write(21'h0002AA, 8'h55);
  endtask

  function automatic logic [AW-1:0] sa(input int sec, input bit a6);
    return {6'(sec), 8'h00, a6, 6'h00};
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset wait", wait_o, 7);
    check("R1 reset psave", ps_o, 0);
    check("R1 reset locks", lock_o, {NS{1'b1}});

    unlock2(); bus_write(21'h000555, 8'hC0); @(negedge clk);
    check("R3 wait A13:12=00", wait_o, 4);
    unlock2(); bus_write(21'h002555, 8'hC0); @(negedge clk);
    check("R3 wait A13:12=10", wait_o, 6);

    // R2: data cycle reuses address latched at last adv edge
    bus_write(21'h000555, 8'hAA);
    @(negedge clk); addr = 21'h0002AA;
    data_only(8'h55, 1);
    bus_write(21'h003555, 8'hC0); @(negedge clk);
    check("R2 stale latch aborts", wait_o, 6);

    // R8: reset command mid sequence, then wrong key
    unlock2(); bus_write(21'h000000, 8'hF0); bus_write(21'h001555, 8'hC0); @(negedge clk);
    check("R8 F0 abort", wait_o, 6);
    bus_write(21'h000555, 8'hAA); bus_write(21'h0002AA, 8'h56); bus_write(21'h001555, 8'hC0);
    @(negedge clk);
    check("R8 wrong key abort", wait_o, 6);

    unlock2(); bus_write(21'h000555, 8'h70); @(negedge clk);
    check("R5 psave set", ps_o, 1);
    bus_write(21'h0, 8'hF0); unlock2(); bus_write(21'h003555, 8'hC0); @(negedge clk);
    check("R5 psave sticky", ps_o, 1);
    check("R3 wait 7", wait_o, 7);

    // R2: held write strobe counts once
    data_only(8'h60, 3);
    bus_write(sa(3, 1), 8'h60); @(negedge clk);
    check("R2 held strobe single", lock_o[3], 1);
    bus_write(21'h0, 8'hF0);

    // R6 / R7 lock stream
    bus_write(21'h000123, 8'h60); bus_write(21'h0ABCDE, 8'h60);
    bus_write(sa(5, 1), 8'h60); @(negedge clk);
    check("R6 unlock sector5", lock_o[5], 0);
    bus_write(sa(9, 1), 8'h60);
    bus_write(sa(9, 0), 8'h12);
    @(negedge clk);
    check("R7 ignored in stream", lock_o[9], 0);
    bus_write(sa(62, 1), 8'h60);
    bus_write(sa(5, 0), 8'h60); @(negedge clk);
    check("R7 stream relock", lock_o[5], 1);
    check("R7 stream unlock 62", lock_o[62], 0);
    bus_write(21'h0, 8'hF0);
    bus_write(sa(9, 0), 8'h60); @(negedge clk);
    check("R7 F0 exits stream", lock_o[9], 0);
    bus_write(21'h0, 8'hF0);

    // overrides
    @(negedge clk); vlo = 1'b1; @(negedge clk);
    check("R9 vpp low all locked", lock_o, {NS{1'b1}});
    vlo = 1'b0; wp_n = 1'b0; @(negedge clk);
    check("R10 wp boot locked", lock_o[62], 1);
    check("R10 wp leaves 9", lock_o[9], 0);
    vhi = 1'b1; @(negedge clk);
    check("R11 vpp high unlocks", lock_o[0], 0);
    check("R10 wp beats vpp high", lock_o[63], 1);
    wp_n = 1'b1; vhi = 1'b0; @(negedge clk);
    check("R11 raw restored", lock_o[0], 1);
    check("R11 raw restored 62", lock_o[62], 0);

    // R12: async reset in a lock stream
    bus_write(21'h0, 8'h60); bus_write(21'h0, 8'h60);
    @(negedge clk); #1 rst_n = 1'b0; model_reset();
    #2;
    check("R12 async wait", wait_o, 7);
    check("R12 async psave", ps_o, 0);
    check("R12 async locks", lock_o, {NS{1'b1}});
    @(negedge clk); rst_n = 1'b1;
    bus_write(sa(7, 1), 8'h60); @(negedge clk);
    check("R12 read mode after reset", lock_o[7], 1);

    repeat (2) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule